// File: doc/BRIEF.md
# Multimode 8-bit Down Counter/Timer

This block is a presettable down counter placed beside a small 8-bit processor. Software writes a reload value into a holding register, picks one of five counting modes and issues start or stop pulses. Once running, the counter decrements on every tick from the selected source. In timebase mode the source is every DIV-th bus timing pulse. In the two event modes it is each rising edge on one of two flag inputs. In the two pulse-width modes it is the prescaled timing pulse, counted only while the selected flag is high.

When the counter passes zero it reloads from the holding register and keeps running. Passing zero also latches an interrupt request, and, when routing is enabled, toggles the Q output. In the pulse-width modes, a falling edge on the selected flag stops the counter. It also latches the interrupt, so the measured value can be read at the counter output.

All control pins are plain single-cycle strobes or levels. No port carries a stream, so the block has no valid/ready handshake. Writes, starts, stops and clears are taken on the edge where they are high, and nothing is ever back-pressured.

Top module: `dtc_timer`

## Requirements
- R1: After reset, the counter reads 0, the holding register holds 0, the counter is stopped, and both irq_o and q_o are low.
- R2: A write updates only the holding register and leaves cnt_o unchanged. A start pulse copies the holding register into the counter and sets it running on the next edge. Start also clears the prescaler.
- R3: Mode 0 (timebase) decrements once per DIV pulses of tpa_i. The tick falls on the DIV-th pulse counted since the last start.
- R4: A tick taken while the counter is 0 reloads the holding register and counting continues, so the underflow period is (reload value + 1) ticks.
- R5: Each underflow sets irq_o. irq_o stays high until irq_clr_i is high on an edge. A set on the same edge overrides the clear.
- R6: q_o toggles on an underflow only when q_route_i is high. Otherwise it holds its level.
- R7: Modes 1 and 2 count rising edges of flag_a_i and flag_b_i respectively. Each flag passes through a two-stage synchronizer and then a registered edge compare, so a change at the counter appears 3 edges after the flag changes. The flag that is not selected has no effect.
- R8: Modes 3 and 4 decrement on each prescaled tick while flag_a_i (mode 3) or flag_b_i (mode 4) is high after synchronizing. A synchronized falling edge of that flag stops the counter, sets irq_o and leaves the count unchanged.
- R9: A stop pulse freezes the counter at its current value without reloading. cnt_o always shows the live counter and never the holding register.
- R10: Mode codes 5 to 7 produce no ticks. Start and stop still act in these modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | W | Reload value |
| mode_i | input | 3 | Count mode (0 timebase, 1/2 events A/B, 3/4 pulse width A/B) |
| q_route_i | input | 1 | Enable underflow toggling of q_o |
| start_i | input | 1 | Load counter from holding register and run |
| stop_i | input | 1 | Freeze counter |
| tpa_i | input | 1 | Bus timing pulse, one cycle wide |
| flag_a_i | input | 1 | External flag A (asynchronous) |
| flag_b_i | input | 1 | External flag B (asynchronous) |
| irq_clr_i | input | 1 | Clear the interrupt request |
| cnt_o | output | W | Live counter value |
| irq_o | output | 1 | Latched interrupt request |
| q_o | output | 1 | Underflow toggle output |

## Verification
The bench keeps W at 8 but builds the block with DIV set to 4 rather than 32. With a short prescale, many timebase underflows, reload wraps and Q toggles fit into a short run, and the pulse-width modes can cross zero during one flag pulse. With W at 8, reload values of 0 and 200 exercise both the one-tick period and a long measurement.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;
  typedef enum logic [2:0] {
    MD_TIMEBASE = 3'd0,
    MD_EVENT_A  = 3'd1,
    MD_EVENT_B  = 3'd2,
    MD_WIDTH_A  = 3'd3,
    MD_WIDTH_B  = 3'd4
  } dtc_mode_e;
endpackage

// File: rtl/dtc_flag_sync.sv
`timescale 1ns/1ps
module dtc_flag_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/dtc_prescale.sv
`timescale 1ns/1ps
module dtc_prescale #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pulse,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = pulse && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
    end else if (pulse) begin
      pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
    end
  end
endmodule

// File: rtl/dtc_core.sv
`timescale 1ns/1ps
module dtc_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         start,
  input  logic         stop,
  input  logic         tick,
  input  logic         pw_mode,
  input  logic         pw_fall,
  input  logic         q_en,
  input  logic         irq_clr,
  output logic [W-1:0] cnt,
  output logic [W-1:0] hold,
  output logic         run,
  output logic         irq,
  output logic         q
);
  logic active, pw_done, uflow, irq_set;

  assign active  = run && !start && !stop;
  assign pw_done = active && pw_mode && pw_fall;
  assign uflow   = active && !(pw_mode && pw_fall) && tick && (cnt == '0);
  assign irq_set = pw_done || uflow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= '0;
      run  <= 1'b0;
      irq  <= 1'b0;
      q    <= 1'b0;
    end else begin
      if (wr_en) hold <= wr_data;
      if (start) begin
        cnt <= hold;
        run <= 1'b1;
      end else if (stop) begin
        run <= 1'b0;
      end else if (pw_done) begin
        run <= 1'b0;
      end else if (active && tick) begin
        cnt <= (cnt == '0) ? hold : cnt - W'(1);
      end
      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (uflow && q_en) q <= ~q;
    end
  end
endmodule

// File: rtl/dtc_timer.sv
`timescale 1ns/1ps
module dtc_timer #(
  parameter int W   = 8,
  parameter int DIV = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [2:0]   mode_i,
  input  logic         q_route_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         tpa_i,
  input  logic         flag_a_i,
  input  logic         flag_b_i,
  input  logic         irq_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         irq_o,
  output logic         q_o
);
  import dtc_pkg::*;

  localparam int NFLAG = 2;

  logic [NFLAG-1:0] flag_in, flag_lvl, flag_rise, flag_fall;
  logic             ptick, tick, pw_mode, pw_fall;
  logic [W-1:0]     hold_q;
  logic             run_q;
  dtc_mode_e        md;

  assign flag_in = {flag_b_i, flag_a_i};
  assign md      = dtc_mode_e'(mode_i);

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    dtc_flag_sync u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (flag_in[g]),
      .lvl  (flag_lvl[g]),
      .rise (flag_rise[g]),
      .fall (flag_fall[g])
    );
  end

  dtc_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_i),
    .pulse(tpa_i),
    .tick (ptick)
  );

  always_comb begin
    tick    = 1'b0;
    pw_mode = 1'b0;
    pw_fall = 1'b0;
    case (md)
      MD_TIMEBASE: tick = ptick;
      MD_EVENT_A:  tick = flag_rise[0];
      MD_EVENT_B:  tick = flag_rise[1];
      MD_WIDTH_A: begin
        tick    = ptick && flag_lvl[0];
        pw_mode = 1'b1;
        pw_fall = flag_fall[0];
      end
      MD_WIDTH_B: begin
        tick    = ptick && flag_lvl[1];
        pw_mode = 1'b1;
        pw_fall = flag_fall[1];
      end
      default: tick = 1'b0;
    endcase
  end

  dtc_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en_i),
    .wr_data(wr_data_i),
    .start  (start_i),
    .stop   (stop_i),
    .tick   (tick),
    .pw_mode(pw_mode),
    .pw_fall(pw_fall),
    .q_en   (q_route_i),
    .irq_clr(irq_clr_i),
    .cnt    (cnt_o),
    .hold   (hold_q),
    .run    (run_q),
    .irq    (irq_o),
    .q      (q_o)
  );
endmodule

// File: rtl/dtc_timer_chk.sv
`timescale 1ns/1ps
module dtc_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         stop_i,
  input logic         q_route_i,
  input logic         irq_clr_i,
  input logic [W-1:0] cnt_o,
  input logic         irq_o,
  input logic         q_o,
  input logic [W-1:0] hold_q,
  input logic         run_q
);
  // R2: start copies the holding register into the counter
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_o == $past(hold_q)));

  // R4: a running counter only holds, steps down by one, or reloads
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start_i) |=> ((cnt_o == $past(cnt_o)) ||
                             (cnt_o == $past(cnt_o) - W'(1)) ||
                             (cnt_o == $past(hold_q))));

  // R5: the request holds until a clear
  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  // R6: Q holds while routing is off
  p_q_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !q_route_i |=> $stable(q_o));

  // R9: a stopped counter is frozen
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> $stable(cnt_o));

  // R9: stop halts the run state
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !run_q);
endmodule

bind dtc_timer dtc_timer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .stop_i   (stop_i),
  .q_route_i(q_route_i),
  .irq_clr_i(irq_clr_i),
  .cnt_o    (cnt_o),
  .irq_o    (irq_o),
  .q_o      (q_o),
  .hold_q   (hold_q),
  .run_q    (run_q)
);

// File: tb/dtc_timer_tb.sv
`timescale 1ns/1ps
module dtc_timer_tb;
  localparam int W   = 8;
  localparam int DIV = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [2:0]   mode_i = 3'd0;
  logic         q_route_i = 1'b0;
  logic         start_i = 1'b0;
  logic         stop_i = 1'b0;
  logic         tpa_i = 1'b0;
  logic         flag_a_i = 1'b0;
  logic         flag_b_i = 1'b0;
  logic         irq_clr_i = 1'b0;
  logic [W-1:0] cnt_o;
  logic         irq_o;
  logic         q_o;

  always #10 clk = ~clk;

  dtc_timer #(.W(W), .DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .mode_i(mode_i), .q_route_i(q_route_i), .start_i(start_i), .stop_i(stop_i),
    .tpa_i(tpa_i), .flag_a_i(flag_a_i), .flag_b_i(flag_b_i), .irq_clr_i(irq_clr_i),
    .cnt_o(cnt_o), .irq_o(irq_o), .q_o(q_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";

  // behavioural reference model
  int m_cnt = 0, m_hold = 0, m_pre = 0;
  bit m_run = 0, m_irq = 0, m_q = 0;
  bit m_a1 = 0, m_a2 = 0, m_a3 = 0, m_b1 = 0, m_b2 = 0, m_b3 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_pre = 0; m_run = 0; m_irq = 0; m_q = 0;
      m_a1 = 0; m_a2 = 0; m_a3 = 0; m_b1 = 0; m_b2 = 0; m_b3 = 0;
    end else begin
      bit ra, fa, rb, fb, pt, tk, pwm, pf, setv;
      ra = m_a2 && !m_a3; fa = !m_a2 && m_a3;
      rb = m_b2 && !m_b3; fb = !m_b2 && m_b3;
      pt = tpa_i && (m_pre == DIV - 1);
      tk = 0; pwm = 0; pf = 0;
      case (mode_i)
        3'd0: tk = pt;
        3'd1: tk = ra;
        3'd2: tk = rb;
        3'd3: begin tk = pt && m_a2; pwm = 1; pf = fa; end
        3'd4: begin tk = pt && m_b2; pwm = 1; pf = fb; end
        default: tk = 0;
      endcase
      setv = 0;
      if (start_i) begin
        m_cnt = m_hold; m_run = 1;
      end else if (stop_i) begin
        m_run = 0;
      end else if (m_run) begin
        if (pwm && pf) begin
          m_run = 0; setv = 1;
        end else if (tk) begin
          if (m_cnt == 0) begin
            m_cnt = m_hold; setv = 1;
            if (q_route_i) m_q = !m_q;
          end else m_cnt = m_cnt - 1;
        end
      end
      if (setv) m_irq = 1;
      else if (irq_clr_i) m_irq = 0;
      if (start_i) m_pre = 0;
      else if (tpa_i) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      m_a3 = m_a2; m_a2 = m_a1; m_a1 = flag_a_i;
      m_b3 = m_b2; m_b2 = m_b1; m_b1 = flag_b_i;
      if (wr_en_i) m_hold = wr_data_i;
    end
  end

  always @(negedge clk) begin
    n_cmp++;
    if (int'(cnt_o) != m_cnt || irq_o !== m_irq || q_o !== m_q) begin
      n_bad++;
      $display("FAIL %s: cnt=%0d irq=%0b q=%0b expected cnt=%0d irq=%0b q=%0b",
               phase, cnt_o, irq_o, q_o, m_cnt, m_irq, m_q);
    end
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1; step(1); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1; step(1); stop_i = 1'b0;
  endtask

  task automatic write_hold(int v);
    wr_en_i = 1'b1; wr_data_i = W'(v); step(1); wr_en_i = 1'b0;
  endtask

  task automatic tpa_train(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tpa_i = 1'b1; step(1); tpa_i = 1'b0; step(gap);
    end
  endtask

  task automatic clear_irq();
    irq_clr_i = 1'b1; step(1); irq_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int snap;
    step(3);
    check("R1 cnt", int'(cnt_o), 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 q", int'(q_o), 0);
    rst_n = 1'b1;
    step(2);

    phase = "R2";
    write_hold(5);
    step(1);
    check("R2 write leaves counter", int'(cnt_o), 0);
    pulse_start();
    check("R2 start loads", int'(cnt_o), 5);

    phase = "R3 R4 R5 R6 timebase";
    q_route_i = 1'b1;
    tpa_train(4, 1);
    check("R3 one tick after DIV pulses", int'(cnt_o), 4);
    tpa_train(40, 1);
    clear_irq();
    tpa_train(30, 2);
    irq_clr_i = 1'b1;
    tpa_train(20, 0);
    irq_clr_i = 1'b0;

    phase = "R4 reload zero";
    write_hold(0);
    pulse_start();
    tpa_train(16, 1);
    check("R4 zero reload holds 0", int'(cnt_o), 0);

    phase = "R6 no route";
    q_route_i = 1'b0;
    write_hold(3);
    pulse_start();
    snap = int'(q_o);
    tpa_train(40, 1);
    check("R6 q held", int'(q_o), snap);

    phase = "R9 stop";
    pulse_stop();
    snap = int'(cnt_o);
    tpa_train(20, 1);
    check("R9 frozen", int'(cnt_o), snap);

    phase = "R7 event A";
    clear_irq();
    mode_i = 3'd1;
    write_hold(3);
    pulse_start();
    for (int i = 0; i < 2; i++) begin
      flag_a_i = 1'b1; step(2); flag_a_i = 1'b0; step(2);
    end
    step(3);
    check("R7 two edges on A", int'(cnt_o), 1);
    for (int i = 0; i < 3; i++) begin
      flag_b_i = 1'b1; step(2); flag_b_i = 1'b0; step(2);
    end
    step(3);
    check("R7 B ignored in mode 1", int'(cnt_o), 1);
    for (int i = 0; i < 5; i++) begin
      flag_a_i = 1'b1; step(3); flag_a_i = 1'b0; step(1);
    end

    phase = "R7 event B";
    mode_i = 3'd2;
    pulse_start();
    for (int i = 0; i < 6; i++) begin
      flag_b_i = 1'b1; flag_a_i = 1'b1; step(2);
      flag_b_i = 1'b0; flag_a_i = 1'b0; step(2);
    end

    phase = "R8 width A";
    clear_irq();
    mode_i = 3'd3;
    write_hold(200);
    pulse_start();
    tpa_train(8, 1);
    check("R8 flag low no count", int'(cnt_o), 200);
    flag_a_i = 1'b1;
    step(3);
    tpa_train(40, 1);
    flag_a_i = 1'b0;
    step(4);
    check("R8 irq on end", int'(irq_o), 1);
    snap = int'(cnt_o);
    tpa_train(12, 1);
    check("R8 count held", int'(cnt_o), snap);

    phase = "R8 width B wrap";
    clear_irq();
    mode_i = 3'd4;
    q_route_i = 1'b1;
    write_hold(2);
    pulse_start();
    flag_b_i = 1'b1;
    tpa_train(30, 1);
    flag_b_i = 1'b0;
    step(5);

    phase = "R10 idle codes";
    clear_irq();
    mode_i = 3'd6;
    write_hold(9);
    pulse_start();
    tpa_train(12, 1);
    flag_a_i = 1'b1; flag_b_i = 1'b1; step(4);
    flag_a_i = 1'b0; flag_b_i = 1'b0; step(4);
    check("R10 no ticks", int'(cnt_o), 9);

    step(3);
    finish_run();
  end
endmodule